// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Register Slave

This block lets a two-wire (I2C) bus master read and write an 8-bit register space inside the chip. It answers to one fixed 7-bit device address. A system clock oversamples the bus lines and finds START, repeated START and STOP conditions. The block receives the device address byte and then a register-pointer byte. After that it either writes the following bytes into the register space or returns register contents to the master. The open-drain data line appears as an output-enable: when `sda_oe` is high the pad pulls SDA low.

On the register side the block drives a pointer address, write data and a one-cycle write strobe. It takes read data back combinationally for the current address. To read, the master first writes the pointer, then issues a repeated START and sends the device address with the read bit set. The pointer advances after every byte written or read, so bursts reach consecutive registers. The system clock must run at least eight times faster than SCL.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset `sda_oe` and `reg_we` are low and SDA is released.
- R2: After a START, an address byte carrying device address 0x74 (bits 7..1, MSB first) with direction bit 0 = write (byte 0xE8) or 1 = read (byte 0xE9) is acknowledged: SDA is held low during the ninth SCL clock.
- R3: An address byte with any other device address gets no acknowledge. Every byte after it gets none either, no register is written, and a read returns 0xFF (bus released), until the next START or STOP.
- R4: In a write transfer, the byte after the address is taken as the register pointer. Each data byte after it gives exactly one `reg_we` pulse of one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The strobe comes after the byte's eighth bit and before its acknowledge clock. Pointer and data bytes are both acknowledged.
- R5: The pointer increments after every data byte written and wraps from 0xFF to 0x00, so a burst writes consecutive registers.
- R6: After a pointer write, a repeated START and the read address, the slave sends `reg_rdata` for the current pointer, MSB first.
- R7: When the master acknowledges a read byte, the slave sends the next register, because the pointer has advanced by one.
- R8: When the master does not acknowledge a read byte, the slave releases SDA. It drives nothing on any later clock until the next START.
- R9: A START or repeated START at any point, including inside a byte, restarts the address phase, drops the partial byte and releases SDA. A STOP releases SDA and returns the slave to idle.
- R10: The slave changes the data line only while SCL is low. Each bit it sends stays stable for the whole SCL high time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_addr | output | PTR_W | Register pointer |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
Two cases are hard to reach from the pins. The first is a repeated START that arrives in the middle of a data byte. The bench sends four bits of that byte and then issues a repeated START, and the scoreboard must show that the abandoned pointer was never written. The second is the released state after a master NACK. The bench reaches it by clocking nine more bit periods without a new START, and it expects SDA to read high on every one of them.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;

   localparam int BYTE_W = 8;
   localparam int BITCNT_W = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_SKIP
   } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Multi-stage synchronizer for one bus line; also exposes the previous level.
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic prev
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign lvl  = chain[STAGES-1];
   assign prev = chain[STAGES];

endmodule

// File: rtl/i2c_bus_events.sv
// Edge and bus-condition decode in the system clock domain.
module i2c_bus_events (
   input  logic scl_lvl,
   input  logic scl_prev,
   input  logic sda_lvl,
   input  logic sda_prev,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   assign scl_rise = scl_lvl & ~scl_prev;
   assign scl_fall = ~scl_lvl & scl_prev;
   assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
   import i2c_regptr_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR  = 7'h74,
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_W       = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_oe,
   output logic [PTR_W-1:0]    reg_addr,
   output logic [BYTE_W-1:0]   reg_wdata,
   output logic                reg_we,
   input  logic [BYTE_W-1:0]   reg_rdata
);

   localparam logic [BITCNT_W-1:0] LAST_TX_BIT = BITCNT_W'(BYTE_W - 1);
   localparam logic [BITCNT_W-1:0] BYTE_FULL   = BITCNT_W'(BYTE_W);

   generate
      if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
         $error("i2c_regptr_slave: PTR_W must be 1..8");
      end
   endgenerate

   logic scl_lvl, scl_prev, sda_lvl, sda_prev;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .lvl(scl_lvl), .prev(scl_prev)
   );

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .lvl(sda_lvl), .prev(sda_prev)
   );

   i2c_bus_events u_events (
      .scl_lvl(scl_lvl), .scl_prev(scl_prev),
      .sda_lvl(sda_lvl), .sda_prev(sda_prev),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   slv_state_t           st;
   logic [BITCNT_W-1:0]  cnt;
   logic [BYTE_W-1:0]    rx_sh;
   logic [BYTE_W-1:0]    tx_sh;
   logic [PTR_W-1:0]     ptr;
   logic                 dir_rd;
   logic                 m_ack;

   wire rx_state = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         dir_rd    <= 1'b0;
         m_ack     <= 1'b0;
         sda_oe    <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (reg_we) ptr <= ptr + 1'b1;

         if (start_ev) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (rx_state) begin
            if (scl_rise && cnt != BYTE_FULL) begin
               rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
               cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_FULL) begin
               unique case (st)
                  ST_ADDR: begin
                     if (rx_sh[BYTE_W-1:1] == SLAVE_ADDR) begin
                        sda_oe <= 1'b1;
                        dir_rd <= rx_sh[0];
                        st     <= ST_ADDR_ACK;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
                  ST_PTR: begin
                     ptr    <= rx_sh[PTR_W-1:0];
                     sda_oe <= 1'b1;
                     st     <= ST_PTR_ACK;
                  end
                  default: begin
                     reg_we    <= 1'b1;
                     reg_wdata <= rx_sh;
                     sda_oe    <= 1'b1;
                     st        <= ST_WR_ACK;
                  end
               endcase
            end
         end else begin
            unique case (st)
               ST_ADDR_ACK: if (scl_fall) begin
                  if (dir_rd) begin
                     tx_sh  <= reg_rdata;
                     sda_oe <= ~reg_rdata[BYTE_W-1];
                     ptr    <= ptr + 1'b1;
                     cnt    <= '0;
                     st     <= ST_RD;
                  end else begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     st     <= ST_PTR;
                  end
               end
               ST_PTR_ACK, ST_WR_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  st     <= ST_WR;
               end
               ST_RD: if (scl_fall) begin
                  if (cnt == LAST_TX_BIT) begin
                     sda_oe <= 1'b0;
                     st     <= ST_RD_ACK;
                  end else begin
                     tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~tx_sh[BYTE_W-2];
                     cnt    <= cnt + 1'b1;
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) m_ack <= ~sda_lvl;
                  else if (scl_fall) begin
                     if (m_ack) begin
                        tx_sh  <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        ptr    <= ptr + 1'b1;
                        cnt    <= '0;
                        st     <= ST_RD;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign reg_addr = ptr;

endmodule

// File: rtl/i2c_regptr_slave_chk.sv
module i2c_regptr_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_oe,
   input logic reg_we,
   input logic scl_lvl,
   input logic scl_fall,
   input logic start_ev,
   input logic stop_ev
);

   // R10
   oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);

   // R10
   oe_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> (!scl_lvl || $past(stop_ev) || $past(start_ev)));

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);

   // R9
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !sda_oe);

   // R4
   we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R4
   we_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(scl_fall));

endmodule

bind i2c_regptr_slave i2c_regptr_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_we(reg_we),
   .scl_lvl(scl_lvl), .scl_fall(scl_fall),
   .start_ev(start_ev), .stop_ev(stop_ev)
);

// File: tb/i2c_regptr_slave_tb.sv
module i2c_regptr_slave_tb;

   localparam int CLK_PERIOD = 10;
   localparam int Q = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_low = 1'b0;
   wire  sda_oe;
   wire  sda = ~(m_low | sda_oe);
   wire [7:0] reg_addr;
   wire [7:0] reg_wdata;
   wire       reg_we;
   logic [7:0] mem [256];
   wire [7:0] reg_rdata = mem[reg_addr];

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [15:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_regptr_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: every write strobe must match the next expected write
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected write", {reg_addr, reg_wdata}, 0);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk({reg_addr, reg_wdata} == e, "R4", "write addr/data",
                {reg_addr, reg_wdata}, e);
         end
         mem[reg_addr] = reg_wdata;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; m_scl = 1'b1; tick(Q);
      m_low = 1'b1; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_restart();
      m_low = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_low = 1'b1; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_low = 1'b0; tick(Q);
   endtask

   task automatic wbit(input logic b);
      m_low = ~b; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic rbit(output logic b, output bit stable);
      logic early;
      m_low = 1'b0; tick(Q);
      m_scl = 1'b1; tick(1);
      early = sda;
      tick(2*Q - 1);
      b = sda;
      stable = (early == b);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      logic b;
      bit s;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b, s);
      ack = ~b;
   endtask

   task automatic rbyte(output logic [7:0] d, input bit give_ack, output bit stable);
      logic b;
      bit s;
      stable = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         rbit(b, s);
         d[i] = b;
         stable &= s;
      end
      wbit(~give_ack);
   endtask

   task automatic send(input logic [7:0] d, input bit exp_ack, input string req);
      logic a;
      wbyte(d, a);
      chk(a == exp_ack, req, "acknowledge", a, exp_ack);
   endtask

   initial begin
      logic [7:0] d;
      bit st;
      logic b;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      tick(4);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
      chk(reg_we == 1'b0, "R1", "reg_we after reset", reg_we, 0);
      chk(sda == 1'b1, "R1", "SDA released after reset", sda, 1);

      // R2 R4 single write
      bus_start();
      send(8'hE8, 1'b1, "R2");
      send(8'h10, 1'b1, "R4");
      exp_q.push_back({8'h10, 8'hA5});
      send(8'hA5, 1'b1, "R4");
      bus_stop();

      // R5 burst write and pointer wrap
      bus_start();
      send(8'hE8, 1'b1, "R2");
      send(8'h20, 1'b1, "R5");
      exp_q.push_back({8'h20, 8'h11}); send(8'h11, 1'b1, "R5");
      exp_q.push_back({8'h21, 8'h22}); send(8'h22, 1'b1, "R5");
      exp_q.push_back({8'h22, 8'h33}); send(8'h33, 1'b1, "R5");
      bus_stop();
      bus_start();
      send(8'hE8, 1'b1, "R2");
      send(8'hFF, 1'b1, "R5");
      exp_q.push_back({8'hFF, 8'hC3}); send(8'hC3, 1'b1, "R5");
      exp_q.push_back({8'h00, 8'h3C}); send(8'h3C, 1'b1, "R5");
      bus_stop();

      // R3 foreign address: no ack, bytes ignored, no writes
      bus_start();
      send(8'hEA, 1'b0, "R3");
      send(8'h10, 1'b0, "R3");
      send(8'h55, 1'b0, "R3");
      bus_stop();
      bus_start();
      send(8'hEB, 1'b0, "R3");
      rbyte(d, 1'b0, st);
      chk(d == 8'hFF, "R3", "foreign read bus level", d, 8'hFF);
      bus_stop();

      // R6 single read (also proves R3 left 0x10 untouched)
      bus_start();
      send(8'hE8, 1'b1, "R2");
      send(8'h10, 1'b1, "R6");
      bus_restart();
      send(8'hE9, 1'b1, "R2");
      rbyte(d, 1'b0, st);
      chk(d == 8'hA5, "R6", "read data", d, 8'hA5);
      chk(st, "R10", "bit stable while SCL high", st, 1);
      bus_stop();

      // R7 burst read, then R8 release after NACK
      bus_start();
      send(8'hE8, 1'b1, "R2");
      send(8'h20, 1'b1, "R7");
      bus_restart();
      send(8'hE9, 1'b1, "R2");
      rbyte(d, 1'b1, st);
      chk(d == 8'h11, "R7", "burst byte 0", d, 8'h11);
      rbyte(d, 1'b1, st);
      chk(d == 8'h22, "R7", "burst byte 1", d, 8'h22);
      chk(st, "R10", "bit stable while SCL high", st, 1);
      rbyte(d, 1'b0, st);
      chk(d == 8'h33, "R7", "burst byte 2", d, 8'h33);
      begin
         bit all_high;
         all_high = 1'b1;
         for (int i = 0; i < 9; i++) begin
            rbit(b, st);
            all_high &= b;
         end
         chk(all_high, "R8", "SDA released after NACK", all_high, 1);
      end
      bus_stop();
      chk(sda_oe == 1'b0, "R9", "released after STOP", sda_oe, 0);

      // R9 repeated START inside a data byte drops it
      bus_start();
      send(8'hE8, 1'b1, "R2");
      send(8'h40, 1'b1, "R9");
      wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
      bus_restart();
      send(8'hE8, 1'b1, "R9");
      send(8'h50, 1'b1, "R9");
      exp_q.push_back({8'h50, 8'h77});
      send(8'h77, 1'b1, "R9");
      bus_stop();
      // read back 0x40 to prove the partial byte never landed
      bus_start();
      send(8'hE8, 1'b1, "R2");
      send(8'h40, 1'b1, "R9");
      bus_restart();
      send(8'hE9, 1'b1, "R2");
      rbyte(d, 1'b0, st);
      chk(d == (8'h40 ^ 8'h5A), "R9", "aborted byte not written", d, 8'h40 ^ 8'h5A);
      bus_stop();

      tick(20);
      chk(exp_q.size() == 0, "R4", "all expected writes seen", exp_q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL R4 watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule